// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block takes a serial stream that has already been sampled, one bit per clock, and finds the frames inside it. Each frame is 12 bits long. It starts with a clock bit of 1, carries ten data bits (bit 0 first), and ends with a clock bit of 0. At every frame boundary the stream therefore has a 0-to-1 step. The detector watches all twelve bit phases at once. It counts, for each phase, how many frames in a row have shown a rising step at that phase. It declares lock when exactly one phase has kept that step for long enough and no other phase is repeating one. Once locked, it delivers each received word in parallel, together with a word strobe and an output enable. Lock is reported on an active-low flag.

Repeating data can also produce a steady rising step at a data position, which could be mistaken for the clock bits. For that reason the detector withholds lock while a second phase is repeating such a step. The one exception is a step from data bit 8 to data bit 9 of the chosen frame, which does not count. When the clock bits go missing for several frames, lock is dropped and the search starts over. A receiver-enable input can switch the parallel outputs off. A power-down input switches the outputs off and also throws away all lock state.

Top module: `eclk_frame_lock`

## Requirements
- R1: The frame is 12 bits long and arrives in this order: a clock bit of 1, then data bits 0 to 9, then a clock bit of 0. While `out_en` is high, `data_out[k]` carries data bit k of a received frame.
- R2: `lock_n` is low while the detector is locked and keeps reporting even when `rx_en` is low. `out_en` is high only when the detector is locked, `rx_en` is high and `pwr_n` is high. While `out_en` is low, `data_out` and `strobe_out` read 0.
- R3: A phase qualifies once 8 consecutive frames have shown a 0-to-1 step at it. Lock is then entered at the next frame boundary that also shows the step. With a clean stream, `lock_n` is still high after 8 frames and low after the 9th frame, and `data_out` then holds the 8th word.
- R4: A second phase that has shown a 0-to-1 step in at least 2 consecutive frames blocks lock. For example, a constant word with bit 3 = 0 and bit 4 = 1 never locks. Lock follows at the first boundary after that repetition breaks.
- R5: A repeating step from data bit 8 (0) to data bit 9 (1) does not block lock. A constant word 0x200 locks after 9 frames.
- R6: While locked, the word is replaced only at the frame boundary (clock bit 1). It is replaced with the frame just completed, and only if that boundary shows the 0-to-1 step. Otherwise the previous word is held.
- R7: Lock is dropped at the 4th consecutive boundary without the 0-to-1 step. Three missing boundaries keep lock.
- R8: After lock is dropped, the search restarts and lock returns after 8 qualifying frames plus one boundary.
- R9: Take the boundary edge where the word updates as bit period 0. With `edge_sel` = 1, `strobe_out` is low after bit periods 0 to 5 and high after bit periods 6 to 11, so its rising edge falls mid-word. With `edge_sel` = 0 the strobe is inverted.
- R10: `pwr_n` low removes the outputs at once and clears lock state at the next clock edge. `lock_n` goes high and the phase history is discarded.
- R11: After reset, `lock_n` is 1, `out_en` is 0, `data_out` is 0 and `strobe_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Sampled serial bit, one per clock |
| rx_en | input | 1 | Output enable request, active high |
| pwr_n | input | 1 | Power-down when low; clears lock state |
| edge_sel | input | 1 | 1: strobe rises mid-word; 0: strobe falls mid-word |
| data_out | output | 10 | Parallel received word |
| strobe_out | output | 1 | Word strobe |
| out_en | output | 1 | Outputs valid (models the driven state) |
| lock_n | output | 1 | Lock flag, active low |

## Verification
The assertions assume that `bit_in` changes at most once per clock and that reset is held for at least two edges. They also assume that `pwr_n` and `edge_sel` change only between frames, so that a strobe or capture check never spans a control change. The stimulus meets these assumptions. It drives whole, back-to-back frames on the falling edge and changes controls only after a frame has been sampled. It builds its acquisition sequences from alternating complementary words, so that no data phase repeats a rising step, except where a test deliberately creates one.

// File: rtl/eclk_pkg.sv
`timescale 1ns/1ps
package eclk_pkg;

    localparam int DEF_DATA_BITS  = 10;
    localparam int DEF_QUAL       = 8;
    localparam int DEF_CONTEND    = 2;
    localparam int DEF_MISS       = 4;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

    // distance from b forward to a on a ring of m positions
    function automatic int ring_dist(int a, int b, int m);
        return (a - b + m) % m;
    endfunction

endpackage

// File: rtl/eclk_phase_track.sv
`timescale 1ns/1ps
module eclk_phase_track #(
    parameter int FRAME = 12,
    parameter int HIST  = 11,
    parameter int QUAL  = 8,
    parameter int PH_W  = 4,
    parameter int RUN_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pwr_n,
    input  logic                        bit_in,
    output logic [PH_W-1:0]             cnt_q,
    output logic [HIST-1:0]             hist_q,
    output logic [FRAME-1:0][RUN_W-1:0] run_q
);

    logic rise;
    assign rise = ~hist_q[0] & bit_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hist_q <= '0;
        end else begin
            cnt_q  <= (cnt_q == PH_W'(FRAME-1)) ? '0 : cnt_q + PH_W'(1);
            hist_q <= {hist_q[HIST-2:0], bit_in};
        end
    end

    for (genvar p = 0; p < FRAME; p++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst || !pwr_n) begin
                run_q[p] <= '0;
            end else if (cnt_q == PH_W'(p)) begin
                if (rise)
                    run_q[p] <= (run_q[p] == RUN_W'(QUAL)) ? run_q[p] : run_q[p] + RUN_W'(1);
                else
                    run_q[p] <= '0;
            end
        end

        AST_RUN_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
            (pwr_n && cnt_q != PH_W'(p)) |=> $stable(run_q[p])); // R3
        AST_RUN_CAP: assert property (@(posedge clk) disable iff (rst)
            run_q[p] <= RUN_W'(QUAL)); // R3
    end

endmodule

// File: rtl/eclk_resolver.sv
`timescale 1ns/1ps
module eclk_resolver #(
    parameter int FRAME   = 12,
    parameter int DATA    = 10,
    parameter int QUAL    = 8,
    parameter int CONTEND = 2,
    parameter int PH_W    = 4,
    parameter int RUN_W   = 4
) (
    input  logic [FRAME-1:0][RUN_W-1:0] run_q,
    output logic                        found,
    output logic [PH_W-1:0]             win
);

    logic [FRAME-1:0] cand, cont, ok;

    for (genvar p = 0; p < FRAME; p++) begin : g_ph
        // the bit8->bit9 step of a frame anchored at p sits DATA phases later
        localparam int EXCL = (p + DATA) % FRAME;
        localparam logic [FRAME-1:0] MASK = (FRAME'(1) << p) | (FRAME'(1) << EXCL);
        assign cand[p] = run_q[p] >= RUN_W'(QUAL);
        assign cont[p] = run_q[p] >= RUN_W'(CONTEND);
        assign ok[p]   = cand[p] && ((cont & ~MASK) == '0);
    end

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = FRAME - 1; i >= 0; i--) begin
            if (ok[i]) begin
                found = 1'b1;
                win   = PH_W'(i);
            end
        end
    end

endmodule

// File: rtl/eclk_lock_fsm.sv
`timescale 1ns/1ps
module eclk_lock_fsm
    import eclk_pkg::*;
#(
    parameter int DATA = 10,
    parameter int HIST = 11,
    parameter int MISS = 4,
    parameter int PH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_n,
    input  logic             bit_in,
    input  logic [PH_W-1:0]  cnt_q,
    input  logic [HIST-1:0]  hist_q,
    input  logic             found,
    input  logic [PH_W-1:0]  win,
    output logic             locked,
    output logic [PH_W-1:0]  phase_q,
    output logic [DATA-1:0]  data_q
);

    localparam int MW = $clog2(MISS + 1);

    trk_state_e     st_q;
    logic [MW-1:0]  miss_q;
    logic [DATA-1:0] word;
    logic           rise;

    assign rise   = ~hist_q[0] & bit_in;
    assign locked = (st_q == ST_TRACK);

    // at a boundary, hist_q[0] is clock bit 0 and data bit k is DATA-k bits back
    for (genvar k = 0; k < DATA; k++) begin : g_word
        assign word[k] = hist_q[DATA-k];
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            st_q    <= ST_HUNT;
            phase_q <= '0;
            miss_q  <= '0;
            data_q  <= '0;
        end else begin
            case (st_q)
                ST_HUNT: begin
                    if (found && cnt_q == win && rise) begin
                        st_q    <= ST_TRACK;
                        phase_q <= win;
                        miss_q  <= '0;
                        data_q  <= word;
                    end
                end
                default: begin
                    if (cnt_q == phase_q) begin
                        if (rise) begin
                            miss_q <= '0;
                            data_q <= word;
                        end else if (miss_q == MW'(MISS - 1)) begin
                            st_q   <= ST_HUNT;
                            miss_q <= '0;
                        end else begin
                            miss_q <= miss_q + MW'(1);
                        end
                    end
                end
            endcase
        end
    end

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(found) && ($past(cnt_q) == phase_q))); // R3
    AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> !locked); // R10
    AST_DROP_AFTER_MISSES: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && $past(pwr_n)) |-> ($past(miss_q) == MW'(MISS - 1))); // R7
    AST_WORD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (!$stable(data_q) && $past(pwr_n)) |-> ($past(cnt_q) == phase_q)); // R6

endmodule

// File: rtl/eclk_out_stage.sv
`timescale 1ns/1ps
module eclk_out_stage
    import eclk_pkg::*;
#(
    parameter int FRAME = 12,
    parameter int DATA  = 10,
    parameter int PH_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic [PH_W-1:0]  cnt_q,
    input  logic [PH_W-1:0]  phase_q,
    input  logic             edge_sel,
    input  logic             rx_en,
    input  logic             pwr_n,
    input  logic [DATA-1:0]  data_q,
    output logic [DATA-1:0]  data_out,
    output logic             strobe_out,
    output logic             out_en
);

    localparam int HALF = FRAME / 2;

    logic strobe_q;
    logic late;

    assign late = ring_dist(int'(cnt_q), int'(phase_q), FRAME) >= HALF;

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= locked && (edge_sel ? late : !late);
    end

    assign out_en     = locked & rx_en & pwr_n;
    assign data_out   = out_en ? data_q : '0;
    assign strobe_out = out_en & strobe_q;

    AST_STROBE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && ($past(cnt_q) == $past(phase_q))) |-> (strobe_q == !$past(edge_sel))); // R9

endmodule

// File: rtl/eclk_frame_lock.sv
`timescale 1ns/1ps
module eclk_frame_lock
    import eclk_pkg::*;
#(
    parameter int DATA_BITS   = DEF_DATA_BITS,
    parameter int QUAL_FRAMES = DEF_QUAL,
    parameter int CONTEND     = DEF_CONTEND,
    parameter int MISS_FRAMES = DEF_MISS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_in,
    input  logic                 rx_en,
    input  logic                 pwr_n,
    input  logic                 edge_sel,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 strobe_out,
    output logic                 out_en,
    output logic                 lock_n
);

    localparam int FRAME = DATA_BITS + 2;
    localparam int HIST  = DATA_BITS + 1;
    localparam int PH_W  = $clog2(FRAME);
    localparam int RUN_W = $clog2(QUAL_FRAMES + 1);

    logic [PH_W-1:0]             cnt_q, win, phase_q;
    logic [HIST-1:0]             hist_q;
    logic [FRAME-1:0][RUN_W-1:0] run_q;
    logic                        found, locked;
    logic [DATA_BITS-1:0]        data_q;

    eclk_phase_track #(
        .FRAME(FRAME), .HIST(HIST), .QUAL(QUAL_FRAMES), .PH_W(PH_W), .RUN_W(RUN_W)
    ) u_track (
        .clk(clk), .rst(rst), .pwr_n(pwr_n), .bit_in(bit_in),
        .cnt_q(cnt_q), .hist_q(hist_q), .run_q(run_q)
    );

    eclk_resolver #(
        .FRAME(FRAME), .DATA(DATA_BITS), .QUAL(QUAL_FRAMES), .CONTEND(CONTEND),
        .PH_W(PH_W), .RUN_W(RUN_W)
    ) u_resolve (
        .run_q(run_q), .found(found), .win(win)
    );

    eclk_lock_fsm #(
        .DATA(DATA_BITS), .HIST(HIST), .MISS(MISS_FRAMES), .PH_W(PH_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .pwr_n(pwr_n), .bit_in(bit_in), .cnt_q(cnt_q),
        .hist_q(hist_q), .found(found), .win(win),
        .locked(locked), .phase_q(phase_q), .data_q(data_q)
    );

    eclk_out_stage #(
        .FRAME(FRAME), .DATA(DATA_BITS), .PH_W(PH_W)
    ) u_out (
        .clk(clk), .rst(rst), .locked(locked), .cnt_q(cnt_q), .phase_q(phase_q),
        .edge_sel(edge_sel), .rx_en(rx_en), .pwr_n(pwr_n), .data_q(data_q),
        .data_out(data_out), .strobe_out(strobe_out), .out_en(out_en)
    );

    assign lock_n = ~locked;

    AST_OUT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        out_en |-> !lock_n); // R2

endmodule

// File: tb/eclk_frame_lock_bench.sv
`timescale 1ns/1ps
module eclk_frame_lock_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       rx_en = 1'b1;
    logic       pwr_n = 1'b1;
    logic       edge_sel = 1'b1;
    logic [9:0] data_out;
    logic       strobe_out, out_en, lock_n;

    int n_chk = 0;
    int n_bad = 0;
    logic mid_strobe;

    always #2.5 clk = ~clk;

    eclk_frame_lock u_eclk_frame_lock (
        .clk(clk), .rst(rst), .bit_in(bit_in), .rx_en(rx_en), .pwr_n(pwr_n),
        .edge_sel(edge_sel), .data_out(data_out), .strobe_out(strobe_out),
        .out_en(out_en), .lock_n(lock_n)
    );

    // {expected locked after the frame, word}; words alternate with complements
    localparam logic [10:0] VEC [14] = '{
        {1'b0, 10'h155}, {1'b0, 10'h2AA}, {1'b0, 10'h0F0}, {1'b0, 10'h30F},
        {1'b0, 10'h123}, {1'b0, 10'h2DC}, {1'b0, 10'h1C7}, {1'b0, 10'h238},
        {1'b1, 10'h3A5}, {1'b1, 10'h001}, {1'b1, 10'h200}, {1'b1, 10'h0FF},
        {1'b1, 10'h3C0}, {1'b1, 10'h2B4}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [9:0] w);
        send_bit(1'b1);
        for (int k = 0; k < 10; k++) begin
            send_bit(w[k]);
            if (k == 1) mid_strobe = strobe_out;
        end
        send_bit(1'b0);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] prev_w;
        prev_w = '0;
        repeat (4) @(posedge clk);
        #1;
        check("R11 lock_n after reset", lock_n, 1);
        check("R11 out_en after reset", out_en, 0);
        check("R11 data_out after reset", data_out, 0);
        check("R11 strobe after reset", strobe_out, 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: acquisition, then locked words (R1 R3 R6 R9)
        for (int i = 0; i < 14; i++) begin
            send_frame(VEC[i][9:0]);
            check("R3 lock flag per frame", lock_n, !VEC[i][10]);
            if (VEC[i][10]) begin
                check("R1 R6 word is previous frame", data_out, prev_w);
                check("R9 strobe high at word end", strobe_out, 1);
                check("R9 strobe low early in word", mid_strobe, 0);
            end
            prev_w = VEC[i][9:0];
        end

        // R2: receiver disable
        rx_en = 1'b0;
        #1;
        check("R2 out_en off with rx_en low", out_en, 0);
        check("R2 data zero with rx_en low", data_out, 0);
        check("R2 strobe zero with rx_en low", strobe_out, 0);
        check("R2 lock flag stays driven", lock_n, 0);
        send_frame(10'h0AB);
        check("R2 lock kept while disabled", lock_n, 0);
        rx_en = 1'b1;
        send_frame(10'h155);
        check("R2 R6 capture continued while disabled", data_out, 10'h0AB);

        // R9: falling-edge strobe selection
        edge_sel = 1'b0;
        send_frame(10'h3FF);
        check("R9 inverted strobe at word end", strobe_out, 0);
        check("R9 inverted strobe early in word", mid_strobe, 1);
        edge_sel = 1'b1;
        send_frame(10'h2C3);

        // R6 R7: missing clock bits
        send_frame(10'h111);
        send_frame(10'h222);
        send_idle(12);
        check("R6 word after first miss", data_out, 10'h111);
        send_idle(12);
        check("R6 word held on second miss", data_out, 10'h111);
        check("R7 lock kept after 2 misses", lock_n, 0);
        send_idle(12);
        check("R7 lock kept after 3 misses", lock_n, 0);
        send_idle(12);
        check("R7 lock dropped after 4 misses", lock_n, 1);
        check("R7 outputs off after drop", out_en, 0);

        // R8: search resumes
        for (int i = 0; i < 8; i++) send_frame(VEC[i][9:0]);
        check("R8 no relock after 8 frames", lock_n, 1);
        send_frame(10'h0C3);
        check("R8 relock after 9th frame", lock_n, 0);
        check("R8 word after relock", data_out, VEC[7][9:0]);

        // R10: power-down
        pwr_n = 1'b0;
        #1;
        check("R10 outputs off at power-down", out_en, 0);
        send_bit(1'b0);
        check("R10 lock cleared", lock_n, 1);
        check("R10 data zero", data_out, 0);
        send_idle(11);
        pwr_n = 1'b1;

        // R4: repetitive step at data bits 3->4 blocks lock
        for (int i = 0; i < 12; i++) send_frame(10'h010);
        check("R4 no lock on repeating data step", lock_n, 1);
        send_frame(10'h3FF);
        check("R4 no lock before a boundary", lock_n, 1);
        send_frame(10'h000);
        check("R4 lock once pattern changes", lock_n, 0);
        check("R4 word after lock", data_out, 10'h3FF);

        // R5: data bit 8->9 step is not a competitor
        pwr_n = 1'b0;
        send_idle(12);
        pwr_n = 1'b1;
        for (int i = 0; i < 8; i++) send_frame(10'h200);
        check("R5 not yet locked after 8", lock_n, 1);
        send_frame(10'h200);
        check("R5 lock despite bit8-bit9 step", lock_n, 0);
        check("R5 word", data_out, 10'h200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule